// File: doc/BRIEF.md
# Two-Way Message Mailbox

The mailbox lets a local processor and a remote host on a PCI-style bus pass 32-bit words to each other. It holds four message registers. Two are inbound: a write to either of them raises an interrupt toward the local processor. Two are outbound: a write to either of them raises an interrupt toward the remote host. Both sides reach all four registers, and two status registers, through their own register ports. Each port has a write enable, an address, write data and combinational read data. Both ports run on one clock.

Every message register has a pending bit, and the direction of that bit is fixed by the register. Inbound pending bits are ORed onto the local interrupt. Outbound pending bits are ORed onto an active-low interrupt toward the remote side. A pending bit stays set until a 1 is written to its position in the matching status register. Either port may do that clearing write. When both ports write the same message register in the same cycle, the remote port's data is kept.

Address map: 0 and 1 are inbound messages 0 and 1. 2 and 3 are outbound messages 0 and 1. 4 is the inbound status register. 5 is the outbound status register. 6 and 7 are unused.

Top module: `msg_mailbox`

## Requirements
- R1: While reset is asserted, and right after it, all pending bits are 0, `loc_irq` is 0, `rem_irq_n` is 1, and both status registers read as 0.
- R2: A write from either port to address 0–3 stores the 32-bit word. The word then reads back unchanged on both ports at the same address.
- R3: A write from either port to address 0 or 1 sets inbound pending bit 0 or 1 at the clock edge that takes the write, so `loc_irq` is 1 after that edge.
- R4: A write from either port to address 2 or 3 sets outbound pending bit 0 or 1 at that edge, so `rem_irq_n` is 0 after it.
- R5: `loc_irq` is 1 exactly when at least one inbound pending bit is set. `rem_irq_n` is 0 exactly when at least one outbound pending bit is set.
- R6: Writing a word to address 4 (inbound) or 5 (outbound), from either port, clears each pending bit whose position (bit 0 or bit 1) holds a 1. Positions that hold 0 are left unchanged, and no message register changes.
- R7: When both ports write the same message register in one cycle, the register takes the remote port's data. The pending bit of that register's own direction is set.
- R8: When a setting write and a clearing write reach the same pending bit in one cycle, the bit ends up set.
- R9: A read of address 4 or 5 returns the pending bits in bits 1:0 and zeros in bits 31:2. Reads of addresses 6 and 7 return 0. Writes to them change nothing.
- R10: Read data is combinational. Changing a port's address shows the addressed register in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_we | input | 1 | Local port write enable |
| loc_addr | input | 3 | Local port register address |
| loc_wdata | input | 32 | Local port write data |
| loc_rdata | output | 32 | Local port read data, combinational |
| rem_we | input | 1 | Remote port write enable |
| rem_addr | input | 3 | Remote port register address |
| rem_wdata | input | 32 | Remote port write data |
| rem_rdata | output | 32 | Remote port read data, combinational |
| loc_irq | output | 1 | Interrupt to the local processor, active high |
| rem_irq_n | output | 1 | Interrupt to the remote host, active low |

## Verification
The assertions assume that both write enables and both addresses hold known values on every clock edge from time zero. They also assume that a status write carries meaningful data only in bits 1:0. The arbitration check assumes that `rem_wdata` holds steady for the whole cycle in which it is sampled. The stimulus meets these assumptions by driving every input to a known idle value at time zero and by changing inputs only on the falling clock edge. Each clearing or setting write is followed by an idle cycle that reads back the affected registers.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW    = 32;
  localparam int MBX_N_IN  = 2;
  localparam int MBX_N_OUT = 2;

  // address bits for n message registers plus two status registers
  function automatic int addr_bits(int n_msg);
    return $clog2(n_msg + 2);
  endfunction

  // decoded write strobe for one register slot
  function automatic logic addr_hit(logic we, int unsigned addr, int unsigned slot);
    return we && (addr == slot);
  endfunction

  // sticky pending update: a set always beats a clear in the same cycle
  function automatic logic [31:0] pend_next(logic [31:0] cur, logic [31:0] set,
                                            logic [31:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int DATA_W = 32,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int ADDR_W = 3
) (
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [N_IN+N_OUT-1:0]   msg_hit,
  output logic [N_IN-1:0]         in_clr,
  output logic [N_OUT-1:0]        out_clr
);
  localparam int N_MSG    = N_IN + N_OUT;
  localparam int IN_STAT  = N_MSG;
  localparam int OUT_STAT = N_MSG + 1;

  logic in_stat_wr;
  logic out_stat_wr;

  for (genvar i = 0; i < N_MSG; i++) begin : g_hit
    assign msg_hit[i] = mbx_pkg::addr_hit(we, 32'(addr), i);
  end

  assign in_stat_wr  = mbx_pkg::addr_hit(we, 32'(addr), IN_STAT);
  assign out_stat_wr = mbx_pkg::addr_hit(we, 32'(addr), OUT_STAT);
  assign in_clr      = in_stat_wr  ? wdata[N_IN-1:0]  : '0;
  assign out_clr     = out_stat_wr ? wdata[N_OUT-1:0] : '0;
endmodule

// File: rtl/mbx_msg_store.sv
module mbx_msg_store #(
  parameter int DATA_W = 32,
  parameter int N_MSG  = 4
) (
  input  logic                          clk,
  input  logic [N_MSG-1:0]              loc_hit,
  input  logic [N_MSG-1:0]              rem_hit,
  input  logic [DATA_W-1:0]             loc_wdata,
  input  logic [DATA_W-1:0]             rem_wdata,
  output logic [N_MSG-1:0]              wr_evt,
  output logic [N_MSG-1:0][DATA_W-1:0]  msg_q
);
  for (genvar i = 0; i < N_MSG; i++) begin : g_slot
    assign wr_evt[i] = loc_hit[i] | rem_hit[i];
    // contents are undefined after reset, so the storage has no reset
    always_ff @(posedge clk) begin
      if (rem_hit[i])      msg_q[i] <= rem_wdata;
      else if (loc_hit[i]) msg_q[i] <= loc_wdata;
    end
  end
endmodule

// File: rtl/mbx_pend.sv
module mbx_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [31:0] nxt;

  assign nxt = mbx_pkg::pend_next(32'(pend), 32'(set), 32'(clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= nxt[N-1:0];
  end
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux #(
  parameter int DATA_W = 32,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [N_IN+N_OUT-1:0][DATA_W-1:0]   msg_q,
  input  logic [N_IN-1:0]                     in_pend,
  input  logic [N_OUT-1:0]                    out_pend,
  output logic [DATA_W-1:0]                   rdata
);
  localparam int N_MSG    = N_IN + N_OUT;
  localparam int IN_STAT  = N_MSG;
  localparam int OUT_STAT = N_MSG + 1;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_MSG; i++) begin
      if (addr == ADDR_W'(i)) rdata = msg_q[i];
    end
    if (addr == ADDR_W'(IN_STAT))  rdata[N_IN-1:0]  = in_pend;
    if (addr == ADDR_W'(OUT_STAT)) rdata[N_OUT-1:0] = out_pend;
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox #(
  parameter int DATA_W = mbx_pkg::MBX_DW,
  parameter int N_IN   = mbx_pkg::MBX_N_IN,
  parameter int N_OUT  = mbx_pkg::MBX_N_OUT,
  parameter int ADDR_W = mbx_pkg::addr_bits(N_IN + N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              rem_we,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic [DATA_W-1:0] rem_wdata,
  output logic [DATA_W-1:0] rem_rdata,
  output logic              loc_irq,
  output logic              rem_irq_n
);
  localparam int N_MSG  = N_IN + N_OUT;
  localparam int N_PORT = 2;  // 0 = local, 1 = remote

  // per-port views of the two register ports
  logic [N_PORT-1:0]                 p_we;
  logic [N_PORT-1:0][ADDR_W-1:0]     p_addr;
  logic [N_PORT-1:0][DATA_W-1:0]     p_wdata;
  logic [N_PORT-1:0][DATA_W-1:0]     p_rdata;
  logic [N_PORT-1:0][N_MSG-1:0]      p_hit;
  logic [N_PORT-1:0][N_IN-1:0]       p_in_clr;
  logic [N_PORT-1:0][N_OUT-1:0]      p_out_clr;

  // named internal events, observed by the checker
  logic [N_MSG-1:0]              loc_msg_hit;
  logic [N_MSG-1:0]              rem_msg_hit;
  logic [N_MSG-1:0]              msg_wr_evt;
  logic [N_IN-1:0]               in_wr_evt;
  logic [N_OUT-1:0]              out_wr_evt;
  logic [N_IN-1:0]               in_clr_req;
  logic [N_OUT-1:0]              out_clr_req;
  logic [N_IN-1:0]               in_pend;
  logic [N_OUT-1:0]              out_pend;
  logic [N_MSG-1:0][DATA_W-1:0]  msg_q;

  assign p_we    = {rem_we, loc_we};
  assign p_addr  = {rem_addr, loc_addr};
  assign p_wdata = {rem_wdata, loc_wdata};

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    mbx_port_dec #(
      .DATA_W(DATA_W), .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W)
    ) u_dec (
      .we      (p_we[p]),
      .addr    (p_addr[p]),
      .wdata   (p_wdata[p]),
      .msg_hit (p_hit[p]),
      .in_clr  (p_in_clr[p]),
      .out_clr (p_out_clr[p])
    );

    mbx_rd_mux #(
      .DATA_W(DATA_W), .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W)
    ) u_rd (
      .addr     (p_addr[p]),
      .msg_q    (msg_q),
      .in_pend  (in_pend),
      .out_pend (out_pend),
      .rdata    (p_rdata[p])
    );
  end

  assign loc_msg_hit = p_hit[0];
  assign rem_msg_hit = p_hit[1];
  assign in_clr_req  = p_in_clr[0]  | p_in_clr[1];
  assign out_clr_req = p_out_clr[0] | p_out_clr[1];

  mbx_msg_store #(.DATA_W(DATA_W), .N_MSG(N_MSG)) u_store (
    .clk       (clk),
    .loc_hit   (loc_msg_hit),
    .rem_hit   (rem_msg_hit),
    .loc_wdata (loc_wdata),
    .rem_wdata (rem_wdata),
    .wr_evt    (msg_wr_evt),
    .msg_q     (msg_q)
  );

  // the low slots feed the local side, the high slots the remote side
  assign in_wr_evt  = msg_wr_evt[N_IN-1:0];
  assign out_wr_evt = msg_wr_evt[N_MSG-1:N_IN];

  mbx_pend #(.N(N_IN)) u_in_pend (
    .clk (clk), .rst_n (rst_n), .set (in_wr_evt), .clr (in_clr_req), .pend (in_pend)
  );

  mbx_pend #(.N(N_OUT)) u_out_pend (
    .clk (clk), .rst_n (rst_n), .set (out_wr_evt), .clr (out_clr_req), .pend (out_pend)
  );

  assign loc_rdata = p_rdata[0];
  assign rem_rdata = p_rdata[1];
  assign loc_irq   = |in_pend;
  assign rem_irq_n = ~(|out_pend);
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int DATA_W = 32,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int ADDR_W = 3
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [ADDR_W-1:0]                     loc_addr,
  input logic [DATA_W-1:0]                     loc_rdata,
  input logic [DATA_W-1:0]                     rem_wdata,
  input logic                                  loc_irq,
  input logic                                  rem_irq_n,
  input logic [N_IN+N_OUT-1:0]                 loc_hit,
  input logic [N_IN+N_OUT-1:0]                 rem_hit,
  input logic [N_IN-1:0]                       in_wr,
  input logic [N_OUT-1:0]                      out_wr,
  input logic [N_IN-1:0]                       in_clr,
  input logic [N_OUT-1:0]                      out_clr,
  input logic [N_IN-1:0]                       in_pend,
  input logic [N_OUT-1:0]                      out_pend,
  input logic [N_IN+N_OUT-1:0][DATA_W-1:0]     msg_q
);
  localparam int N_MSG   = N_IN + N_OUT;
  localparam int IN_STAT = N_MSG;

  // R1
  irq_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!loc_irq && rem_irq_n && in_pend == '0 && out_pend == '0));

  // R5
  loc_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_irq) |-> $past(|in_wr));

  // R5
  rem_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rem_irq_n) |-> $past(|out_wr));

  // R9
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_addr == ADDR_W'(IN_STAT)) |-> (loc_rdata[DATA_W-1:N_IN] == '0));

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    // R3
    in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_wr[i] |=> (in_pend[i] && loc_irq));
    // R6
    in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_clr[i] && !in_wr[i]) |=> !in_pend[i]);
    // R8
    in_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_pend[i]) |-> $past(in_clr[i] && !in_wr[i]));
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    // R4
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr[i] |=> (out_pend[i] && !rem_irq_n));
    // R6
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_clr[i] && !out_wr[i]) |=> !out_pend[i]);
    // R8
    out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_pend[i]) |-> $past(out_clr[i] && !out_wr[i]));
  end

  for (genvar i = 0; i < N_MSG; i++) begin : g_arb
    // R7
    remote_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_hit[i] && rem_hit[i]) |=> (msg_q[i] == $past(rem_wdata)));
  end
endmodule

bind msg_mailbox mbx_chk #(
  .DATA_W(DATA_W), .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loc_addr  (loc_addr),
  .loc_rdata (loc_rdata),
  .rem_wdata (rem_wdata),
  .loc_irq   (loc_irq),
  .rem_irq_n (rem_irq_n),
  .loc_hit   (loc_msg_hit),
  .rem_hit   (rem_msg_hit),
  .in_wr     (in_wr_evt),
  .out_wr    (out_wr_evt),
  .in_clr    (in_clr_req),
  .out_clr   (out_clr_req),
  .in_pend   (in_pend),
  .out_pend  (out_pend),
  .msg_q     (msg_q)
);

// File: tb/msg_mailbox_tb.sv
module msg_mailbox_tb;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int NV = 10;

  typedef struct packed {
    logic          lwe;
    logic [AW-1:0] la;
    logic [DW-1:0] ld;
    logic          rwe;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    logic [AW-1:0] lchk_a;
    logic [DW-1:0] lchk_v;
    logic [AW-1:0] rchk_a;
    logic [DW-1:0] rchk_v;
    logic          e_irq;
    logic          e_irq_n;
  } vec_t;

  // Each entry is one write cycle, then one idle cycle that reads back and checks.
  localparam vec_t VEC [NV] = '{
    // R2 R3: local writes inbound 0
    '{1'b1, 3'd0, 32'hA1A1_0001, 1'b0, 3'd0, 32'h0,
      3'd0, 32'hA1A1_0001, 3'd4, 32'h1, 1'b1, 1'b1},
    // R2 R4: remote writes outbound 1
    '{1'b0, 3'd0, 32'h0, 1'b1, 3'd3, 32'hB2B2_0003,
      3'd3, 32'hB2B2_0003, 3'd5, 32'h2, 1'b1, 1'b0},
    // R6: remote clears inbound 0, message stays
    '{1'b0, 3'd0, 32'h0, 1'b1, 3'd4, 32'h0000_0001,
      3'd4, 32'h0, 3'd0, 32'hA1A1_0001, 1'b0, 1'b0},
    // R6: zero in bit 1 of an outbound status write leaves bit 1 set
    '{1'b1, 3'd5, 32'hFFFF_FFFD, 1'b0, 3'd0, 32'h0,
      3'd5, 32'h2, 3'd3, 32'hB2B2_0003, 1'b0, 1'b0},
    // R7: both ports write inbound 1, remote data kept
    '{1'b1, 3'd1, 32'h1111_1111, 1'b1, 3'd1, 32'h2222_2222,
      3'd1, 32'h2222_2222, 3'd4, 32'h2, 1'b1, 1'b0},
    // R8: set and clear of outbound 1 in one cycle, bit stays set
    '{1'b1, 3'd3, 32'h3333_3333, 1'b1, 3'd5, 32'h0000_0002,
      3'd5, 32'h2, 3'd3, 32'h3333_3333, 1'b1, 1'b0},
    // R5 R6: local clears inbound 1, remote writes outbound 0
    '{1'b1, 3'd4, 32'h0000_0002, 1'b1, 3'd2, 32'h4444_4444,
      3'd4, 32'h0, 3'd5, 32'h3, 1'b0, 1'b0},
    // R9: unmapped read, R5 remote irq released
    '{1'b1, 3'd0, 32'h5555_5555, 1'b1, 3'd5, 32'h0000_0003,
      3'd6, 32'h0, 3'd4, 32'h1, 1'b1, 1'b1},
    // R9: write to unmapped address has no effect
    '{1'b1, 3'd4, 32'h0000_0001, 1'b1, 3'd7, 32'hFFFF_FFFF,
      3'd2, 32'h4444_4444, 3'd7, 32'h0, 1'b0, 1'b1},
    // R3: remote writes inbound 0
    '{1'b0, 3'd0, 32'h0, 1'b1, 3'd0, 32'h6666_6666,
      3'd0, 32'h6666_6666, 3'd5, 32'h0, 1'b1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loc_we = 1'b0;
  logic [AW-1:0] loc_addr = '0;
  logic [DW-1:0] loc_wdata = '0;
  logic [DW-1:0] loc_rdata;
  logic          rem_we = 1'b0;
  logic [AW-1:0] rem_addr = '0;
  logic [DW-1:0] rem_wdata = '0;
  logic [DW-1:0] rem_rdata;
  logic          loc_irq;
  logic          rem_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msg_mailbox u_dut (
    .clk (clk), .rst_n (rst_n),
    .loc_we (loc_we), .loc_addr (loc_addr), .loc_wdata (loc_wdata), .loc_rdata (loc_rdata),
    .rem_we (rem_we), .rem_addr (rem_addr), .rem_wdata (rem_wdata), .rem_rdata (rem_rdata),
    .loc_irq (loc_irq), .rem_irq_n (rem_irq_n)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle_read(logic [AW-1:0] la, logic [AW-1:0] ra);
    @(negedge clk);
    loc_we = 1'b0; rem_we = 1'b0;
    loc_addr = la; rem_addr = ra;
    loc_wdata = '0; rem_wdata = '0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    // R1: state while in reset
    repeat (3) @(negedge clk);
    loc_addr = 3'd4; rem_addr = 3'd5; #1;
    check("R1 loc_irq in reset", 32'(loc_irq), 32'h0);
    check("R1 rem_irq_n in reset", 32'(rem_irq_n), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    idle_read(3'd4, 3'd5);
    check("R1 inbound status after reset", loc_rdata, 32'h0);
    check("R1 outbound status after reset", rem_rdata, 32'h0);
    check("R1 rem_irq_n after reset", 32'(rem_irq_n), 32'h1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      loc_we = VEC[v].lwe; loc_addr = VEC[v].la; loc_wdata = VEC[v].ld;
      rem_we = VEC[v].rwe; rem_addr = VEC[v].ra; rem_wdata = VEC[v].rd;
      idle_read(VEC[v].lchk_a, VEC[v].rchk_a);
      check($sformatf("R2/R9 vec %0d loc_rdata", v), loc_rdata, VEC[v].lchk_v);
      check($sformatf("R2/R9 vec %0d rem_rdata", v), rem_rdata, VEC[v].rchk_v);
      check($sformatf("R5 vec %0d loc_irq", v), 32'(loc_irq), 32'(VEC[v].e_irq));
      check($sformatf("R5 vec %0d rem_irq_n", v), 32'(rem_irq_n), 32'(VEC[v].e_irq_n));
    end

    // R10: read data follows the address with no clock edge between
    @(negedge clk);
    loc_addr = 3'd1; #1;
    check("R10 loc read addr 1", loc_rdata, 32'h2222_2222);
    loc_addr = 3'd3; #1;
    check("R10 loc read addr 3", loc_rdata, 32'h3333_3333);
    rem_addr = 3'd2; #1;
    check("R10 rem read addr 2", rem_rdata, 32'h4444_4444);

    // R4 R6: local writes outbound 0 and then clears it
    @(negedge clk);
    loc_we = 1'b1; loc_addr = 3'd2; loc_wdata = 32'h7777_7777;
    idle_read(3'd5, 3'd2);
    check("R4 outbound 0 pending", loc_rdata, 32'h1);
    check("R4 rem_irq_n asserted", 32'(rem_irq_n), 32'h0);
    check("R2 outbound 0 on remote", rem_rdata, 32'h7777_7777);
    @(negedge clk);
    rem_we = 1'b1; rem_addr = 3'd5; rem_wdata = 32'h0000_0001;
    idle_read(3'd5, 3'd2);
    check("R6 outbound 0 cleared", loc_rdata, 32'h0);
    check("R6 rem_irq_n released", 32'(rem_irq_n), 32'h1);
    check("R6 message unchanged by clear", rem_rdata, 32'h7777_7777);

    // R1: reset in mid-run drops pending inbound 0
    check("R1 loc_irq before reset", 32'(loc_irq), 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 loc_irq during reset", 32'(loc_irq), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_read(3'd4, 3'd5);
    check("R1 inbound status after second reset", loc_rdata, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule